// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This block sits beside the receiver, transmitter and modem-status logic of a 16550-style serial port. It holds the four-bit interrupt enable register, combines the level conditions that those neighbours raise, and picks the single most urgent enabled cause. It shows that cause as an encoded identification byte on a read port and drives one registered, active-high interrupt line.

The transmit-holding-empty cause is an event, not a level. It is latched when the holding register drains, or when its enable is switched on while the register is already empty. It is dropped when the holding register is refilled, or when the identification byte is read while that byte names it as the cause. Software that needs the value later must keep its own copy of the byte. The other causes follow their input levels directly. Bits 7:6 of the byte report whether FIFO mode is on.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, the identification byte reads 0x01 with FIFO mode off (0xC1 with it on), and the interrupt output is 0.
- R2: A write to the enable register takes effect at the next clock edge. Enable bit 0 gates received data and character timeout, bit 1 gates transmit holding empty, bit 2 gates line status, and bit 3 gates modem status. A source whose enable bit is 0 has no effect on the identification byte or on the interrupt output.
- R3: Identification bit 0 is 0 while any enabled source is pending and 1 otherwise.
- R4: Identification bits 3:0 read 0x6 for line status, 0x4 for received data, 0xC for character timeout, 0x2 for transmit holding empty, 0x0 for modem status, and 0x1 when nothing is pending.
- R5: The byte names the highest pending enabled source. The order, highest first, is: line status, received data, character timeout, transmit holding empty, modem status.
- R6: Identification bits 7:6 both equal the FIFO-mode input, and bits 5:4 read 0.
- R7: The transmit-empty source is latched on the edge where the holding-empty input goes from 0 to 1.
- R8: Writing enable bit 1 from 0 to 1 while the holding-empty input is 1 latches the transmit-empty source.
- R9: A read of the identification byte while it shows 0x2 in bits 3:0 clears the transmit-empty source. A read while a higher source is shown leaves it latched.
- R10: The transmit-empty source clears when the holding-empty input is 0.
- R11: The interrupt output equals, one cycle later, the inverse of identification bit 0.
- R12: The line-status source is pending when any of the four error inputs (overrun, parity, framing, break) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| ier_rdata | output | 4 | Enable register contents |
| iir_rd | input | 1 | Identification register read strobe (side effect) |
| iir_data | output | 8 | Identification byte |
| fifo_en | input | 1 | FIFO mode is on |
| rx_avail | input | 1 | Received data is available |
| rx_timeout | input | 1 | Character timeout is pending |
| thr_empty | input | 1 | Transmit holding register is empty |
| err_flags | input | 4 | Overrun, parity, framing and break flags |
| modem_delta | input | 1 | A modem status line changed |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check the timing of the interrupt line against the identification bit 0 and the FIFO flag bits. They also check that line status wins whenever it is enabled, that an empty enable register leaves nothing pending, and that a read which names the transmit-empty cause removes it. The order of the lower sources, and the arming of the transmit-empty cause by an edge or by an enable write, involve input history. Only the bench's reference model shows these, across its directed scenarios.

// File: rtl/uart_irq_pkg.sv
// Package: shared widths and identification codes of the interrupt identifier.
// Assumes the source index order below is the priority order, index 0 highest.
package uart_irq_pkg;
    localparam int IER_W   = 4;
    localparam int ERR_W   = 4;
    localparam int NUM_SRC = 5;
    localparam int CODE_W  = 4;

    // Sources in priority order
    typedef enum logic [2:0] {
        SRC_LINE  = 3'd0,
        SRC_RDATA = 3'd1,
        SRC_TMO   = 3'd2,
        SRC_THRE  = 3'd3,
        SRC_MODEM = 3'd4
    } src_e;

    localparam logic [CODE_W-1:0] CODE_NONE = 4'h1;

    // Identification code (bits 3:0, bit 0 = 0 meaning pending) of each source
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            0:       return 4'h6;
            1:       return 4'h4;
            2:       return 4'hC;
            3:       return 4'h2;
            default: return 4'h0;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_thre_src.sv
// Module: transmit-holding-empty event source.
// Latches on a 0->1 change of the empty level or on an enable write that turns
// the source on while empty; clears on refill or on an identification read that
// currently names this source. Setting wins over clearing in the same cycle.
module uart_irq_thre_src (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic en_q,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic ack,
    output logic pend
);
    logic empty_q;
    logic arm;
    logic drop;

    // Detect a new arming event from the level edge or an enable switch-on
    always_comb begin
        arm  = (thr_empty && !empty_q) || (en_wr && en_wdata && !en_q && thr_empty);
        drop = !thr_empty || ack;
    end

    // Hold the latched event and the previous empty level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            pend    <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            if (arm)
                pend <= 1'b1;
            else if (drop)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority selector over the masked source requests.
// Assumes request index 0 is the most urgent; produces a one-hot grant and the
// identification code of the granted source (CODE_NONE when none is granted).
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]      req,
    output logic [N-1:0]      grant,
    output logic [CODE_W-1:0] code
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    // One priority stage per source: grant if requested and nothing above
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign grant[i]     = req[i] && !blocked[i];
        assign blocked[i+1] = blocked[i] || req[i];
    end

    // Merge the code of the granted source
    always_comb begin
        code = CODE_NONE;
        for (int i = 0; i < N; i++)
            if (grant[i]) code = src_code(i);
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Module: interrupt enable register, source masking, identification byte and
// registered interrupt line of a 16550-style serial port.
// Assumes all event inputs are synchronous levels from neighbouring logic and
// that iir_rd pulses for one cycle per bus read of the identification byte.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [IER_W-1:0] ier_wdata,
    output logic [IER_W-1:0] ier_rdata,
    input  logic             iir_rd,
    output logic [7:0]       iir_data,
    input  logic             fifo_en,
    input  logic             rx_avail,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic [ERR_W-1:0] err_flags,
    input  logic             modem_delta,
    output logic             irq
);
    logic [IER_W-1:0]   ier_q;
    logic               thre_pend;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] grant;
    logic [CODE_W-1:0]  code;

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ier_q <= '0;
        else if (ier_wr)
            ier_q <= ier_wdata;
    end

    uart_irq_thre_src u_thre (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_empty(thr_empty),
        .en_q     (ier_q[1]),
        .en_wr    (ier_wr),
        .en_wdata (ier_wdata[1]),
        .ack      (iir_rd && grant[SRC_THRE]),
        .pend     (thre_pend)
    );

    // Mask each raw condition with its enable bit, in priority order
    always_comb begin
        req            = '0;
        req[SRC_LINE]  = ier_q[2] && (|err_flags);
        req[SRC_RDATA] = ier_q[0] && rx_avail;
        req[SRC_TMO]   = ier_q[0] && rx_timeout;
        req[SRC_THRE]  = ier_q[1] && thre_pend;
        req[SRC_MODEM] = ier_q[3] && modem_delta;
    end

    uart_irq_prio #(.N(NUM_SRC)) u_prio (
        .req  (req),
        .grant(grant),
        .code (code)
    );

    // Registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |req;
    end

    assign iir_data  = {fifo_en, fifo_en, 2'b00, code};
    assign ier_rdata = ier_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Module: property checker for the interrupt identifier, bound to its top.
// Assumes it sees only top-level ports.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic [3:0] ier_rdata,
    input logic       iir_rd,
    input logic [7:0] iir_data,
    input logic       fifo_en,
    input logic       thr_empty,
    input logic [3:0] err_flags,
    input logic       irq
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (ier_rdata == 4'h0 && !irq)); // R1
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n) (ier_rdata == 4'h0) |-> iir_data[0]); // R2
    AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (ier_rdata[2] && |err_flags) |-> (iir_data[3:0] == 4'h6)); // R5
    AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) iir_data[7:4] == {fifo_en, fifo_en, 2'b00}); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_data[3:0] == 4'h2 && !ier_wr && thr_empty && $past(thr_empty))
        |=> (iir_data[3:0] != 4'h2)); // R9
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (irq == !$past(iir_data[0]))); // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ier_wr   (ier_wr),
    .ier_rdata(ier_rdata),
    .iir_rd   (iir_rd),
    .iir_data (iir_data),
    .fifo_en  (fifo_en),
    .thr_empty(thr_empty),
    .err_flags(err_flags),
    .irq      (irq)
);

// File: tb/tb_uart_irq_ident.sv
// Bench: behavioural reference model compared on every cycle, plus directed
// scenarios; each scenario sets the requirement tag used in failure lines.
module tb_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [3:0] ier_wdata = '0;
    logic [3:0] ier_rdata;
    logic       iir_rd = 1'b0;
    logic [7:0] iir_data;
    logic       fifo_en = 1'b0;
    logic       rx_avail = 1'b0;
    logic       rx_timeout = 1'b0;
    logic       thr_empty = 1'b0;
    logic [3:0] err_flags = '0;
    logic       modem_delta = 1'b0;
    logic       irq;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";

    // Reference model state
    int m_ier = 0;
    int m_thre = 0;
    int m_prev_empty = 1;
    int m_irq = 0;

    always #5 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .iir_rd(iir_rd), .iir_data(iir_data),
        .fifo_en(fifo_en), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
        .thr_empty(thr_empty), .err_flags(err_flags), .modem_delta(modem_delta),
        .irq(irq)
    );

    function automatic int exp_low();
        if ((m_ier & 4) != 0 && err_flags != 0) return 6;
        if ((m_ier & 1) != 0 && rx_avail) return 4;
        if ((m_ier & 1) != 0 && rx_timeout) return 12;
        if ((m_ier & 2) != 0 && m_thre != 0) return 2;
        if ((m_ier & 8) != 0 && modem_delta) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] exp_iir();
        return {fifo_en, fifo_en, 2'b00, 4'(exp_low())};
    endfunction

    // Advance the model at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ier = 0; m_thre = 0; m_prev_empty = 1; m_irq = 0;
        end else begin
            int low;
            int nt;
            low = exp_low();
            m_irq = (low != 1) ? 1 : 0;
            nt = m_thre;
            if (!thr_empty) nt = 0;
            if (iir_rd && low == 2) nt = 0;
            if (thr_empty && m_prev_empty == 0) nt = 1;
            if (ier_wr && ier_wdata[1] && (m_ier & 2) == 0 && thr_empty) nt = 1;
            m_thre = nt;
            m_prev_empty = thr_empty ? 1 : 0;
            if (ier_wr) m_ier = int'(ier_wdata);
        end
    end

    // Compare outputs 3 ns after each rising edge
    always @(posedge clk) begin
        #3;
        n_checks++;
        if (iir_data !== exp_iir() || irq !== m_irq[0] || ier_rdata !== 4'(m_ier)) begin
            n_fail++;
            $display("FAIL %s: iir=%02h irq=%0b ier=%0h expected iir=%02h irq=%0b ier=%0h",
                     tag, iir_data, irq, ier_rdata, exp_iir(), m_irq[0], 4'(m_ier));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ier(input logic [3:0] v);
        ier_wr = 1'b1; ier_wdata = v;
        step(1);
        ier_wr = 1'b0;
    endtask

    task automatic read_iir();
        iir_rd = 1'b1;
        step(1);
        iir_rd = 1'b0;
    endtask

    task automatic expect_low(input string t, input logic [3:0] e);
        n_checks++;
        if (iir_data[3:0] !== e) begin
            n_fail++;
            $display("FAIL %s: iir[3:0]=%0h expected %0h", t, iir_data[3:0], e);
        end
    endtask

    initial begin
        #20000000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        thr_empty = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
        tag = "R1";
        expect_low("R1", 4'h1);

        // R2: all sources high, nothing enabled
        tag = "R2";
        rx_avail = 1; rx_timeout = 1; err_flags = 4'h1; modem_delta = 1;
        step(3);
        expect_low("R2", 4'h1);
        rx_avail = 0; rx_timeout = 0; err_flags = 0; modem_delta = 0;
        step(1);

        // R8: enable transmit-empty while already empty
        tag = "R8";
        set_ier(4'h2);
        expect_low("R8", 4'h2);

        // R9: read clears the transmit-empty cause
        tag = "R9";
        read_iir();
        expect_low("R9", 4'h1);

        // R7 / R10: refill then drain
        tag = "R10";
        thr_empty = 0; step(2);
        tag = "R7";
        thr_empty = 1; step(1);
        expect_low("R7", 4'h2);
        tag = "R10";
        thr_empty = 0; step(1);
        expect_low("R10", 4'h1);
        thr_empty = 1; step(1);

        // R12 / R4: each error flag alone, all enabled
        set_ier(4'hF);
        for (int b = 0; b < 4; b++) begin
            tag = "R12";
            err_flags = 4'(1 << b);
            step(1);
            expect_low("R12", 4'h6);
        end
        err_flags = 0;

        // R9: read while line status shown keeps transmit-empty latched
        tag = "R9";
        err_flags = 4'h2; step(1);
        read_iir();
        err_flags = 0; step(1);
        expect_low("R9", 4'h2);

        // R5 / R4: peel sources off from the top
        tag = "R5";
        err_flags = 4'h8; rx_avail = 1; rx_timeout = 1; modem_delta = 1;
        step(1); expect_low("R5", 4'h6);
        err_flags = 0; step(1); expect_low("R5", 4'h4);
        rx_avail = 0; step(1); expect_low("R4", 4'hC);
        rx_timeout = 0; step(1); expect_low("R4", 4'h2);
        tag = "R4";
        read_iir(); expect_low("R4", 4'h0);
        modem_delta = 0; step(1);
        tag = "R3";
        expect_low("R3", 4'h1);

        // R2: masking each enable bit individually
        tag = "R2";
        rx_avail = 1; modem_delta = 1; set_ier(4'hE);
        expect_low("R2", 4'h0);
        set_ier(4'h7); expect_low("R2", 4'h4);
        rx_avail = 0; modem_delta = 0; step(1);

        // R6: FIFO flag bits
        tag = "R6";
        fifo_en = 1; step(2);
        fifo_en = 0; step(2);

        // R11: interrupt follows identification bit 0 a cycle later
        tag = "R11";
        modem_delta = 1; set_ier(4'h8); step(1);
        modem_delta = 0; step(2);

        // R1: reset in mid-activity
        tag = "R1";
        err_flags = 4'h4; set_ier(4'hF);
        rst_n = 0; step(2);
        rst_n = 1; step(1);
        expect_low("R1", 4'h1);
        err_flags = 0; step(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule